// File: doc/BRIEF.md
# Host/Accelerator Message Mailbox

The block carries short fixed-width messages between a host processor and an accelerator core. Messages from the host reach the core through a small first-in first-out queue. Messages from the core reach the host through a set of single-entry holding slots. One of these slots drives a level interrupt toward the host whenever it holds a message.

The two sides behave differently. The core side is blocking. It takes messages with a valid/ready handshake, so a core that reads an empty queue or writes an occupied slot waits until the other side acts. The host side never waits. A host write to a full queue completes at once: the message is discarded and a sticky overflow flag is set. A host read of an empty slot also completes at once and returns zero with its valid bit low. Each side sees occupancy counts for its own direction. Address decoding and interrupt aggregation are left to the surrounding logic.

Top module: `mbox_unit`

## Requirements
- R1: After reset the queue is empty: `c_rd_valid`=0, `c_in_count`=0 and `h_in_free`=4. Both slots are empty: `h_out_full`=0 and `c_out_free`=2'b11. `irq`=0 and `h_ovf`=0.
- R2: The inbound queue holds four 32-bit messages. The core receives them in exactly the order the host wrote them.
- R3: While the queue is empty, `c_rd_valid` is low and a core holding `c_rd_ready` high takes nothing. A message written by the host at one clock edge is presented on `c_rd_data` with `c_rd_valid` high right after that edge.
- R4: A host write to a full queue in a cycle with no core pop is discarded. The queued contents are unchanged. `h_ovf` goes high after that edge and stays high until reset.
- R5: A host write to a full queue in the same cycle as a core pop is accepted. The count stays 4, the new message becomes the newest entry, and `h_ovf` is not set.
- R6: A core write (`c_wr_valid`, slot chosen by `c_wr_sel`) to an empty slot sees `c_wr_ready`=1 in that cycle, and the slot is occupied after the edge. A core write to an occupied slot sees `c_wr_ready`=0 until the host reads that slot, and the stored message is unchanged.
- R7: When the host reads an occupied slot in the same cycle as a core write to that slot, the read wins. The host gets the old message, `c_wr_ready` is 1 in that cycle, and the slot holds the new message afterwards.
- R8: A host read (`h_rd_en`, slot chosen by `h_rd_sel`) of an empty slot returns `h_rd_data`=0 and `h_rd_valid`=0 in the same cycle.
- R9: A host read of an occupied slot returns its message with `h_rd_valid`=1 in the same cycle. With no concurrent core write, the slot is empty after that edge.
- R10: `irq` is high exactly while slot 1 holds a message. It drops in the same cycle that the host reads slot 1. Slot 0 never drives `irq`.
- R11: Status outputs: `h_in_free` is 4 minus the queue count, and `c_in_count` equals the queue count. Bit i of `h_out_full` is 1 when slot i is occupied, and bit i of `c_out_free` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr_en | input | 1 | Host pushes a message into the inbound queue |
| h_wr_data | input | 32 | Host message |
| h_rd_en | input | 1 | Host reads an outbound slot |
| h_rd_sel | input | 1 | Slot the host reads (1 = interrupting slot) |
| h_rd_data | output | 32 | Message read by the host, zero if none |
| h_rd_valid | output | 1 | Host read returned a message |
| h_in_free | output | 3 | Free inbound queue entries |
| h_out_full | output | 2 | Per-slot occupancy seen by the host |
| h_ovf | output | 1 | Sticky inbound drop flag |
| irq | output | 1 | Level interrupt while slot 1 is occupied |
| c_rd_ready | input | 1 | Core waits for an inbound message |
| c_rd_valid | output | 1 | Inbound message available |
| c_rd_data | output | 32 | Oldest inbound message |
| c_in_count | output | 3 | Inbound queue count seen by the core |
| c_wr_valid | input | 1 | Core offers an outbound message |
| c_wr_sel | input | 1 | Slot the core writes |
| c_wr_data | input | 32 | Core message |
| c_wr_ready | output | 1 | Core write accepted this cycle |
| c_out_free | output | 2 | Per-slot empty flags seen by the core |

## Verification
Host read data, `h_rd_valid`, `c_wr_ready` and the falling `irq` on a slot-1 read are combinational. The bench checks them in the same cycle as the stimulus, shortly after driving the inputs and well before the next rising edge. Queue counts, `c_rd_valid`, `c_rd_data`, slot occupancy, a rising `irq` and `h_ovf` all change one edge after the triggering access. The bench drives inputs just after a rising edge and reads these registered results just after the following edge. The race cases (R5, R7) put both accesses in one cycle, check that cycle's combinational outputs, and then check the stored state one edge later.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   // Bits needed to hold a count from 0 to depth inclusive.
   function automatic int unsigned count_bits(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

   // Bits needed to select one of n slots (at least one bit).
   function automatic int unsigned sel_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   // Power-of-two test used by elaboration checks.
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/mbox_in_fifo.sv
module mbox_in_fifo
   import mbox_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 4
)(
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [DATA_W-1:0]                    wr_data,
   input  logic                                 rd_ready,
   output logic                                 rd_valid,
   output logic [DATA_W-1:0]                    rd_data,
   output logic [count_bits(DEPTH)-1:0]         count,
   output logic [count_bits(DEPTH)-1:0]         free,
   output logic                                 ovf
);
   localparam int unsigned PTR_W = (DEPTH <= 1) ? 1 : $clog2(DEPTH);
   localparam int unsigned CNT_W = count_bits(DEPTH);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   generate
      if (DEPTH < 2 || !is_pow2(DEPTH)) begin : g_bad_depth
         $error("mbox_in_fifo: DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("mbox_in_fifo: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] store [DEPTH];
   logic [PTR_W-1:0]  head_q, tail_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              ovf_q;
   logic              is_full, is_empty, pop, push, drop;

   assign is_full  = (cnt_q == FULL_CNT);
   assign is_empty = (cnt_q == '0);
   assign pop      = rd_ready && !is_empty;
   // A push into a full queue is allowed when a pop frees a slot this cycle.
   assign push     = wr_en && (!is_full || pop);
   assign drop     = wr_en && !push;

   always_ff @(posedge clk) begin
      if (push) begin
         store[tail_q] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (push) tail_q <= tail_q + PTR_W'(1);
         if (pop)  head_q <= head_q + PTR_W'(1);
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
         if (drop) ovf_q <= 1'b1;
      end
   end

   assign rd_valid = !is_empty;
   assign rd_data  = store[head_q];
   assign count    = cnt_q;
   assign free     = FULL_CNT - cnt_q;
   assign ovf      = ovf_q;

   AST_IN_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT) else $error("queue count above depth"); // R2

   AST_IN_EMPTY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (is_empty && rd_ready) |=> (cnt_q <= CNT_W'(1))) else $error("pop from empty queue"); // R3

   AST_IN_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_full && !rd_ready) |=> (ovf_q && cnt_q == FULL_CNT)) else $error("full write not dropped"); // R4

   AST_IN_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q) else $error("overflow flag cleared"); // R4

   AST_IN_SWAP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_full && rd_ready) |=> (cnt_q == FULL_CNT && $stable(ovf_q))) else $error("pop+push on full failed"); // R5

endmodule

// File: rtl/mbox_out_slot.sv
module mbox_out_slot #(
   parameter int unsigned DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_rd,
   input  logic              core_req,
   input  logic [DATA_W-1:0] core_data,
   output logic              core_ready,
   output logic              full,
   output logic [DATA_W-1:0] data
);
   logic              full_q;
   logic [DATA_W-1:0] data_q;
   logic              take;

   // Read-first: a host read in this cycle frees the slot for the core.
   assign core_ready = !full_q || host_rd;
   assign take       = core_req && core_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else begin
         if (take) begin
            full_q <= 1'b1;
            data_q <= core_data;
         end else if (host_rd) begin
            full_q <= 1'b0;
         end
      end
   end

   assign full = full_q;
   assign data = data_q;

   AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !host_rd) |=> (full_q && $stable(data_q))) else $error("occupied slot changed"); // R6

   AST_SLOT_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && host_rd && core_req) |=> full_q) else $error("race lost the core message"); // R7

   AST_SLOT_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !core_req) |=> !full_q) else $error("read did not empty slot"); // R9

endmodule

// File: rtl/mbox_unit.sv
module mbox_unit
   import mbox_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IN_DEPTH = 4,
   parameter int unsigned N_OUT    = 2,
   parameter int unsigned IRQ_SLOT = 1
)(
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               h_wr_en,
   input  logic [DATA_W-1:0]                  h_wr_data,
   input  logic                               h_rd_en,
   input  logic [sel_bits(N_OUT)-1:0]         h_rd_sel,
   output logic [DATA_W-1:0]                  h_rd_data,
   output logic                               h_rd_valid,
   output logic [count_bits(IN_DEPTH)-1:0]    h_in_free,
   output logic [N_OUT-1:0]                   h_out_full,
   output logic                               h_ovf,
   output logic                               irq,
   input  logic                               c_rd_ready,
   output logic                               c_rd_valid,
   output logic [DATA_W-1:0]                  c_rd_data,
   output logic [count_bits(IN_DEPTH)-1:0]    c_in_count,
   input  logic                               c_wr_valid,
   input  logic [sel_bits(N_OUT)-1:0]         c_wr_sel,
   input  logic [DATA_W-1:0]                  c_wr_data,
   output logic                               c_wr_ready,
   output logic [N_OUT-1:0]                   c_out_free
);
   localparam int unsigned SEL_W = sel_bits(N_OUT);
   localparam int unsigned CNT_W = count_bits(IN_DEPTH);

   generate
      if (N_OUT < 1) begin : g_bad_nout
         $error("mbox_unit: N_OUT must be at least 1");
      end
      if (IRQ_SLOT >= N_OUT) begin : g_bad_irq
         $error("mbox_unit: IRQ_SLOT must name an existing slot");
      end
   endgenerate

   // Inbound queue, host to core
   logic [CNT_W-1:0] in_cnt, in_free;

   mbox_in_fifo #(.DATA_W(DATA_W), .DEPTH(IN_DEPTH)) u_in (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (h_wr_en),
      .wr_data  (h_wr_data),
      .rd_ready (c_rd_ready),
      .rd_valid (c_rd_valid),
      .rd_data  (c_rd_data),
      .count    (in_cnt),
      .free     (in_free),
      .ovf      (h_ovf)
   );

   assign c_in_count = in_cnt;
   assign h_in_free  = in_free;

   // Outbound slots, core to host
   logic [N_OUT-1:0]  slot_full, slot_rd, slot_req, slot_rdy;
   logic [DATA_W-1:0] slot_data [N_OUT];

   for (genvar gi = 0; gi < N_OUT; gi++) begin : g_slot
      assign slot_rd[gi]  = h_rd_en    && (h_rd_sel == SEL_W'(gi));
      assign slot_req[gi] = c_wr_valid && (c_wr_sel == SEL_W'(gi));

      mbox_out_slot #(.DATA_W(DATA_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .host_rd    (slot_rd[gi]),
         .core_req   (slot_req[gi]),
         .core_data  (c_wr_data),
         .core_ready (slot_rdy[gi]),
         .full       (slot_full[gi]),
         .data       (slot_data[gi])
      );
   end

   // Host read return and core write handshake
   always_comb begin
      h_rd_valid = 1'b0;
      h_rd_data  = '0;
      c_wr_ready = 1'b0;
      for (int i = 0; i < N_OUT; i++) begin
         if (slot_rd[i] && slot_full[i]) begin
            h_rd_valid = 1'b1;
            h_rd_data  = slot_data[i];
         end
         if (c_wr_sel == SEL_W'(i)) begin
            c_wr_ready = slot_rdy[i];
         end
      end
   end

   assign h_out_full = slot_full;
   assign c_out_free = ~slot_full;
   // Level interrupt; drops in the cycle the host reads the slot.
   assign irq = slot_full[IRQ_SLOT] && !slot_rd[IRQ_SLOT];

   AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> h_out_full[IRQ_SLOT]) else $error("irq without message"); // R10

   AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (c_wr_valid && c_wr_ready && c_wr_sel == SEL_W'(IRQ_SLOT)) |=> h_out_full[IRQ_SLOT]) else $error("irq slot not filled"); // R10

   AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (h_rd_en && !h_out_full[h_rd_sel]) |-> (h_rd_data == '0 && !h_rd_valid)) else $error("empty read returned data"); // R8

   AST_STATUS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (CNT_W'(h_in_free + c_in_count) == CNT_W'(IN_DEPTH))) else $error("status counts disagree"); // R11

endmodule

// File: tb/sim_mbox_unit.sv
`timescale 1ns/1ps
module sim_mbox_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_wr_en = 1'b0;
   logic [31:0] h_wr_data = '0;
   logic        h_rd_en = 1'b0;
   logic        h_rd_sel = 1'b0;
   logic [31:0] h_rd_data;
   logic        h_rd_valid;
   logic [2:0]  h_in_free;
   logic [1:0]  h_out_full;
   logic        h_ovf;
   logic        irq;
   logic        c_rd_ready = 1'b0;
   logic        c_rd_valid;
   logic [31:0] c_rd_data;
   logic [2:0]  c_in_count;
   logic        c_wr_valid = 1'b0;
   logic        c_wr_sel = 1'b0;
   logic [31:0] c_wr_data = '0;
   logic        c_wr_ready;
   logic [1:0]  c_out_free;

   int n_run = 0;
   int n_fail = 0;
   logic [31:0] exp_q [4];

   always #4 clk = ~clk;

   mbox_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .h_wr_en(h_wr_en), .h_wr_data(h_wr_data),
      .h_rd_en(h_rd_en), .h_rd_sel(h_rd_sel),
      .h_rd_data(h_rd_data), .h_rd_valid(h_rd_valid),
      .h_in_free(h_in_free), .h_out_full(h_out_full),
      .h_ovf(h_ovf), .irq(irq),
      .c_rd_ready(c_rd_ready), .c_rd_valid(c_rd_valid),
      .c_rd_data(c_rd_data), .c_in_count(c_in_count),
      .c_wr_valid(c_wr_valid), .c_wr_sel(c_wr_sel),
      .c_wr_data(c_wr_data), .c_wr_ready(c_wr_ready),
      .c_out_free(c_out_free)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Advance past a rising edge; registered results are settled afterwards.
   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic fill_queue(input logic [31:0] base);
      h_wr_en = 1'b1;
      for (int i = 0; i < 4; i++) begin
         h_wr_data = base + 32'(i);
         exp_q[i]  = base + 32'(i);
         step();
      end
      h_wr_en = 1'b0;
      #1;
   endtask

   task automatic drain_check(input string tag);
      c_rd_ready = 1'b1;
      for (int i = 0; i < 4; i++) begin
         #1;
         check({tag, " valid"}, 32'(c_rd_valid), 32'd1);
         check({tag, " order"}, c_rd_data, exp_q[i]);
         step();
      end
      c_rd_ready = 1'b0;
      #1;
      check({tag, " empty after drain"}, 32'(c_rd_valid), 32'd0);
   endtask

   task automatic t_reset();
      check("R1 c_rd_valid", 32'(c_rd_valid), 32'd0);
      check("R1 c_in_count", 32'(c_in_count), 32'd0);
      check("R1 h_in_free", 32'(h_in_free), 32'd4);
      check("R1 h_out_full", 32'(h_out_full), 32'd0);
      check("R1 c_out_free", 32'(c_out_free), 32'd3);
      check("R1 irq", 32'(irq), 32'd0);
      check("R1 h_ovf", 32'(h_ovf), 32'd0);
   endtask

   task automatic t_order();
      fill_queue(32'hA5A5_0010);
      check("R11 h_in_free full", 32'(h_in_free), 32'd0);
      check("R11 c_in_count full", 32'(c_in_count), 32'd4);
      drain_check("R2");
      check("R11 c_in_count drained", 32'(c_in_count), 32'd0);
      check("R11 h_in_free drained", 32'(h_in_free), 32'd4);
   endtask

   task automatic t_core_stall();
      c_rd_ready = 1'b1;
      for (int i = 0; i < 3; i++) begin
         step();
         check("R3 stall valid", 32'(c_rd_valid), 32'd0);
         check("R3 stall count", 32'(c_in_count), 32'd0);
      end
      h_wr_en = 1'b1;
      h_wr_data = 32'hC0DE_0001;
      step();
      h_wr_en = 1'b0;
      #1;
      check("R3 release valid", 32'(c_rd_valid), 32'd1);
      check("R3 release data", c_rd_data, 32'hC0DE_0001);
      step();
      check("R3 popped", 32'(c_rd_valid), 32'd0);
      c_rd_ready = 1'b0;
   endtask

   task automatic t_full_swap();
      fill_queue(32'h0BAD_0100);
      c_rd_ready = 1'b1;
      h_wr_en = 1'b1;
      h_wr_data = 32'h5EED_0F0F;
      #1;
      check("R5 head before swap", c_rd_data, 32'h0BAD_0100);
      step();
      h_wr_en = 1'b0;
      c_rd_ready = 1'b0;
      #1;
      check("R5 count stays full", 32'(c_in_count), 32'd4);
      check("R5 no overflow", 32'(h_ovf), 32'd0);
      exp_q[0] = 32'h0BAD_0101;
      exp_q[1] = 32'h0BAD_0102;
      exp_q[2] = 32'h0BAD_0103;
      exp_q[3] = 32'h5EED_0F0F;
      drain_check("R5");
   endtask

   task automatic t_overflow();
      fill_queue(32'hF00D_0200);
      h_wr_en = 1'b1;
      h_wr_data = 32'hDEAD_BEEF;
      step();
      h_wr_en = 1'b0;
      #1;
      check("R4 overflow set", 32'(h_ovf), 32'd1);
      check("R4 count unchanged", 32'(c_in_count), 32'd4);
      drain_check("R4");
      step();
      step();
      check("R4 overflow sticky", 32'(h_ovf), 32'd1);
   endtask

   task automatic t_empty_read();
      h_rd_en = 1'b1;
      h_rd_sel = 1'b0;
      #1;
      check("R8 empty data slot0", h_rd_data, 32'd0);
      check("R8 empty valid slot0", 32'(h_rd_valid), 32'd0);
      h_rd_sel = 1'b1;
      #1;
      check("R8 empty data slot1", h_rd_data, 32'd0);
      check("R8 empty valid slot1", 32'(h_rd_valid), 32'd0);
      step();
      h_rd_en = 1'b0;
      #1;
      check("R8 slots still empty", 32'(h_out_full), 32'd0);
   endtask

   task automatic t_slot_race();
      c_wr_valid = 1'b1;
      c_wr_sel = 1'b0;
      c_wr_data = 32'h1111_2222;
      #1;
      check("R6 ready on empty", 32'(c_wr_ready), 32'd1);
      step();
      c_wr_data = 32'h3333_4444;
      #1;
      check("R6 slot0 occupied", 32'(h_out_full), 32'd1);
      check("R11 c_out_free", 32'(c_out_free), 32'd2);
      check("R10 slot0 no irq", 32'(irq), 32'd0);
      check("R6 stall ready", 32'(c_wr_ready), 32'd0);
      step();
      check("R6 still stalled", 32'(c_wr_ready), 32'd0);
      h_rd_en = 1'b1;
      h_rd_sel = 1'b0;
      #1;
      check("R7 ready on race", 32'(c_wr_ready), 32'd1);
      check("R7 old data to host", h_rd_data, 32'h1111_2222);
      check("R7 host valid", 32'(h_rd_valid), 32'd1);
      step();
      c_wr_valid = 1'b0;
      #1;
      check("R7 slot refilled", 32'(h_out_full), 32'd1);
      check("R9 read new data", h_rd_data, 32'h3333_4444);
      check("R9 read valid", 32'(h_rd_valid), 32'd1);
      step();
      h_rd_en = 1'b0;
      #1;
      check("R9 slot drained", 32'(h_out_full), 32'd0);
   endtask

   task automatic t_irq();
      c_wr_valid = 1'b1;
      c_wr_sel = 1'b1;
      c_wr_data = 32'h1A1A_0001;
      step();
      c_wr_valid = 1'b0;
      #1;
      check("R10 irq raised", 32'(irq), 32'd1);
      check("R11 slot1 full", 32'(h_out_full), 32'd2);
      check("R11 c_out_free slot1", 32'(c_out_free), 32'd1);
      h_rd_en = 1'b1;
      h_rd_sel = 1'b0;
      #1;
      check("R10 other read keeps irq", 32'(irq), 32'd1);
      step();
      h_rd_sel = 1'b1;
      #1;
      check("R10 irq drops same cycle", 32'(irq), 32'd0);
      check("R9 irq slot data", h_rd_data, 32'h1A1A_0001);
      step();
      h_rd_en = 1'b0;
      #1;
      check("R10 irq stays low", 32'(irq), 32'd0);
      check("R9 slot1 drained", 32'(h_out_full), 32'd0);
   endtask

   initial begin
      #(8 * 100000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      #1;
      t_reset();
      t_order();
      t_core_stall();
      t_full_swap();
      t_overflow();
      t_empty_read();
      t_slot_race();
      t_irq();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule